// File: doc/BRIEF.md
# Eight-bit function-coded arithmetic and logic unit

This block is a purely combinational datapath element. It takes two 8-bit operands, B and C, and a 3-bit function code, and returns one 8-bit result plus three flags: carry, sign and zero. A ripple-carry adder and a per-bit logic unit evaluate every candidate result at the same time. A 3-to-8 decoder turns the function code into one-hot source enables, and a shared AND-OR result bus passes on the value of the one enabled source.

Sign and zero are both taken from the result bus. They therefore also describe the idle bus that the no-operation code leaves behind. Carry is only meaningful for the two arithmetic codes. A surrounding datapath registers the operands and flags and chooses the function code.

Top module: `alu8_core`

## Requirements
- R1: Code 3'b000 drives result = (B + C) mod 256, and carry = bit 8 of the 9-bit sum, which is formed with a carry-in of 0.
- R2: Code 3'b001 drives result = (B + 1) mod 256 using the same adder, and carry = bit 8 of that sum. B = 0xFF gives result 0x00 with carry 1.
- R3: Codes 3'b010, 3'b011 and 3'b100 drive the bitwise AND, OR and XOR of B and C, in that order.
- R4: Code 3'b101 drives the bitwise complement of B. C has no effect on the result.
- R5: Code 3'b110 rotates B left by one place. Result bit i+1 takes B bit i, and result bit 0 takes B bit 7.
- R6: Code 3'b111 enables no source. The result is 0x00, zero is 1, sign is 0 and carry is 0, whatever the operands are.
- R7: For every code other than 3'b000 and 3'b001, carry is 0.
- R8: Zero is 1 exactly when all eight result bits are 0, and sign always equals result bit 7, under every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_b | input | 8 | First operand; the only operand for increment, complement and rotate |
| opnd_c | input | 8 | Second operand |
| func_sel | input | 3 | Function code selecting the result source |
| result | output | 8 | Value on the shared result bus |
| flag_carry | output | 1 | Adder carry-out, gated to the arithmetic codes |
| flag_sign | output | 1 | Bit 7 of the result bus |
| flag_zero | output | 1 | High when the result bus is all zeros |

## Verification
Every output is combinational, so each result and flag is due in the same cycle as the stimulus and carries no register delay. The bench changes operands and function code on the falling clock edge. It samples all four outputs 2 ns later, well before the next rising edge, so every value it reads has settled from the current stimulus alone. For each code it runs every pairing of the corner operands 0x00, 0x7F, 0x80 and 0xFF, then a seeded random sweep. All comparisons are made against a reference function that is written directly from the requirements.

// File: rtl/alu8_pkg.sv
// Package: shared function-code encoding and widths for the 8-bit ALU.
// Assumes the code width fixes the number of result sources (2**FUNC_W).
package alu8_pkg;
    localparam int FUNC_W = 3;
    localparam int NUM_FN = 1 << FUNC_W;

    typedef enum logic [FUNC_W-1:0] {
        FN_ADD  = 3'd0,
        FN_INC  = 3'd1,
        FN_AND  = 3'd2,
        FN_OR   = 3'd3,
        FN_XOR  = 3'd4,
        FN_NOT  = 3'd5,
        FN_ROL  = 3'd6,
        FN_IDLE = 3'd7
    } alu_fn_e;
endpackage

// File: rtl/alu8_ripple.sv
// Module: ripple-carry adder built from chained full adders.
// Assumes carry-in at bit 0 is tied low; carry-out of the top bit is exported.
module alu8_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] add_a,
    input  logic [W-1:0] add_b,
    output logic [W-1:0] add_sum,
    output logic         add_cout
);
    logic [W:0] chain;

    // Carry chain starts from a constant zero.
    assign chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_fa
            // One full adder per bit position.
            assign add_sum[i]  = add_a[i] ^ add_b[i] ^ chain[i];
            assign chain[i+1]  = (add_a[i] & add_b[i]) | (chain[i] & (add_a[i] ^ add_b[i]));
        end
    endgenerate

    // Carry out of the most significant stage.
    assign add_cout = chain[W];
endmodule

// File: rtl/alu8_bitlogic.sv
// Module: per-bit logic unit producing NOT B, AND, OR and XOR in parallel.
// Assumes both operands share width W; every output is always valid.
module alu8_bitlogic #(
    parameter int W = 8
) (
    input  logic [W-1:0] lg_b,
    input  logic [W-1:0] lg_c,
    output logic [W-1:0] lg_not,
    output logic [W-1:0] lg_and,
    output logic [W-1:0] lg_or,
    output logic [W-1:0] lg_xor
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // Independent one-bit logic cell.
            assign lg_not[i] = ~lg_b[i];
            assign lg_and[i] = lg_b[i] & lg_c[i];
            assign lg_or[i]  = lg_b[i] | lg_c[i];
            assign lg_xor[i] = lg_b[i] ^ lg_c[i];
        end
    endgenerate
endmodule

// File: rtl/alu8_fn_decode.sv
// Module: binary-to-one-hot decoder for result-bus source enables.
// Assumes IDLE_CODE names a code that enables nothing (the bus stays idle).
module alu8_fn_decode #(
    parameter int SEL_W     = 3,
    parameter int IDLE_CODE = 7,
    localparam int N_OUT    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] dec_sel,
    output logic [N_OUT-1:0] dec_en
);
    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_line
            if (i == IDLE_CODE) begin : g_idle
                // The idle code drives no source.
                assign dec_en[i] = 1'b0;
            end else begin : g_active
                // Enable line i is high only for its own code.
                assign dec_en[i] = (dec_sel == SEL_W'(i));
            end
        end
    endgenerate
endmodule

// File: rtl/alu8_core.sv
// Module: top of the function-coded ALU. All candidate results are computed
// in parallel; a one-hot enable gates exactly one onto an AND-OR result bus,
// and sign/zero are derived from that bus. Purely combinational: no clock
// or reset. Assumes W >= 2 so the rotate has a distinct top and bottom bit.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      opnd_b,
    input  logic [W-1:0]      opnd_c,
    input  logic [FUNC_W-1:0] func_sel,
    output logic [W-1:0]      result,
    output logic              flag_carry,
    output logic              flag_sign,
    output logic              flag_zero
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [NUM_FN-1:0] fn_en;
    logic [W-1:0]      add_rhs;
    logic [W-1:0]      sum_v;
    logic              sum_cout;
    logic [W-1:0]      not_v, and_v, or_v, xor_v, rol_v;
    logic [W-1:0]      src [NUM_FN];
    logic [W-1:0]      bus_v;

    // Decode the function code into one-hot source enables.
    alu8_fn_decode #(
        .SEL_W     (FUNC_W),
        .IDLE_CODE (int'(FN_IDLE))
    ) u_dec (
        .dec_sel (func_sel),
        .dec_en  (fn_en)
    );

    // Increment reuses the adder with the second operand forced to one.
    assign add_rhs = fn_en[FN_INC] ? ONE : opnd_c;

    alu8_ripple #(.W(W)) u_add (
        .add_a    (opnd_b),
        .add_b    (add_rhs),
        .add_sum  (sum_v),
        .add_cout (sum_cout)
    );

    alu8_bitlogic #(.W(W)) u_logic (
        .lg_b   (opnd_b),
        .lg_c   (opnd_c),
        .lg_not (not_v),
        .lg_and (and_v),
        .lg_or  (or_v),
        .lg_xor (xor_v)
    );

    // Circular left rotate by one: top bit wraps into bit 0.
    assign rol_v = {opnd_b[W-2:0], opnd_b[W-1]};

    // Map each code to its source; the idle code has a constant zero source.
    assign src[FN_ADD]  = sum_v;
    assign src[FN_INC]  = sum_v;
    assign src[FN_AND]  = and_v;
    assign src[FN_OR]   = or_v;
    assign src[FN_XOR]  = xor_v;
    assign src[FN_NOT]  = not_v;
    assign src[FN_ROL]  = rol_v;
    assign src[FN_IDLE] = '0;

    // Wired-OR result bus: each source contributes only while enabled.
    always_comb begin
        bus_v = '0;
        for (int k = 0; k < NUM_FN; k++) begin
            bus_v = bus_v | (src[k] & {W{fn_en[k]}});
        end
    end

    assign result = bus_v;

    // Flags: carry only for the arithmetic codes; sign and zero from the bus.
    assign flag_carry = sum_cout & (fn_en[FN_ADD] | fn_en[FN_INC]);
    assign flag_sign  = bus_v[W-1];
    assign flag_zero  = ~|bus_v;
endmodule

// File: rtl/alu8_core_chk.sv
// Module: assertion checker for alu8_core, bound to every instance below.
// Assumes combinational settling; uses immediate assertions in always_comb.
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic [W-1:0]      opnd_b,
    input logic [W-1:0]      opnd_c,
    input logic [FUNC_W-1:0] func_sel,
    input logic [W-1:0]      result,
    input logic              flag_carry,
    input logic              flag_sign,
    input logic              flag_zero,
    input logic [NUM_FN-1:0] fn_en
);
    // Check port-level relations whenever inputs or outputs change.
    always_comb begin
        if (!$isunknown({opnd_b, opnd_c, func_sel})) begin
            // R6
            en_onehot_chk: assert ($countones(fn_en) == ((func_sel == FN_IDLE) ? 0 : 1))
                else $error("decoder enable count wrong for code %0d", func_sel);
            // R1
            add_sum_chk: assert (func_sel != FN_ADD ||
                                 {flag_carry, result} == ({1'b0, opnd_b} + {1'b0, opnd_c}))
                else $error("add mismatch");
            // R2
            inc_wrap_chk: assert (!(func_sel == FN_INC && opnd_b == '1) ||
                                  (result == '0 && flag_carry))
                else $error("increment wrap mismatch");
            // R4
            not_inv_chk: assert (func_sel != FN_NOT || (result ^ opnd_b) == '1)
                else $error("complement mismatch");
            // R5
            rol_wrap_chk: assert (func_sel != FN_ROL || result[0] == opnd_b[W-1])
                else $error("rotate wrap bit mismatch");
            // R6
            idle_bus_chk: assert (func_sel != FN_IDLE ||
                                  (result == '0 && flag_zero && !flag_sign && !flag_carry))
                else $error("idle code left bus active");
            // R7
            carry_gate_chk: assert (func_sel == FN_ADD || func_sel == FN_INC || !flag_carry)
                else $error("carry set for non-arithmetic code");
            // R8
            zero_flag_chk: assert (!flag_zero || !flag_sign)
                else $error("zero and sign both set");
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_alu8_core_chk (
    .opnd_b     (opnd_b),
    .opnd_c     (opnd_c),
    .func_sel   (func_sel),
    .result     (result),
    .flag_carry (flag_carry),
    .flag_sign  (flag_sign),
    .flag_zero  (flag_zero),
    .fn_en      (fn_en)
);

// File: tb/test_alu8_core.sv
// Bench: directed corner operands for every code plus a seeded random sweep,
// compared against a reference function written from the requirements.
module test_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_b = '0;
    logic [7:0] opnd_c = '0;
    logic [2:0] func_sel = '0;
    logic [7:0] result;
    logic       flag_carry, flag_sign, flag_zero;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    alu8_core i_alu8_core (
        .opnd_b     (opnd_b),
        .opnd_c     (opnd_c),
        .func_sel   (func_sel),
        .result     (result),
        .flag_carry (flag_carry),
        .flag_sign  (flag_sign),
        .flag_zero  (flag_zero)
    );

    // Reference: {carry, result} per requirement R1..R7.
    function automatic logic [8:0] ref_alu(input logic [2:0] fn, input logic [7:0] b,
                                           input logic [7:0] c);
        logic [8:0] s;
        case (fn)
            3'd0: s = {1'b0, b} + {1'b0, c};
            3'd1: s = {1'b0, b} + 9'd1;
            3'd2: s = {1'b0, b & c};
            3'd3: s = {1'b0, b | c};
            3'd4: s = {1'b0, b ^ c};
            3'd5: s = {1'b0, ~b};
            3'd6: s = {1'b0, b[6:0], b[7]};
            default: s = 9'd0;
        endcase
        return s;
    endfunction

    function automatic string res_tag(input logic [2:0] fn);
        case (fn)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2, 3'd3, 3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: code=%0d b=%h c=%h actual=%h expected=%h",
                     tag, func_sel, opnd_b, opnd_c, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 2 ns later (outputs are combinational).
    task automatic apply(input logic [2:0] fn, input logic [7:0] b, input logic [7:0] c);
        logic [8:0] e;
        @(negedge clk);
        func_sel = fn;
        opnd_b   = b;
        opnd_c   = c;
        #2;
        e = ref_alu(fn, b, c);
        check(res_tag(fn), result, e[7:0]);
        check((fn <= 3'd1) ? res_tag(fn) : "R7", {7'd0, flag_carry}, {7'd0, e[8]});
        check("R8", {7'd0, flag_sign}, {7'd0, e[7]});
        check("R8", {7'd0, flag_zero}, {7'd0, (e[7:0] == 8'd0)});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] corners [4];
        int unsigned seed;
        corners[0] = 8'h00; corners[1] = 8'h7F; corners[2] = 8'h80; corners[3] = 8'hFF;
        seed = 32'd20240611;
        void'($urandom(seed));

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero operands under add give zero result with zero flag (R1, R8).
        apply(3'd0, 8'h00, 8'h00);

        // R2: increment wraps from 0xFF with carry.
        apply(3'd1, 8'hFF, 8'h00);
        // R5: rotate moves bit 7 to bit 0.
        apply(3'd6, 8'h80, 8'h00);
        // R4: C has no effect on complement.
        apply(3'd5, 8'h3C, 8'hFF);
        apply(3'd5, 8'h3C, 8'h00);
        // R6: idle code with busy operands.
        apply(3'd7, 8'hFF, 8'hFF);
        // R1: maximum add carry.
        apply(3'd0, 8'hFF, 8'hFF);

        // Every code over every corner operand pair (R1..R8).
        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    apply(3'(f), corners[i], corners[j]);

        // Seeded random sweep across all codes.
        for (int n = 0; n < 2000; n++)
            apply(3'($urandom() % 8), 8'($urandom()), 8'($urandom()));

        finish_run();
    end
endmodule